// File: doc/BRIEF.md
# Transmit Underflow Recovery Controller

This block watches over a ring of transmit descriptors while a transmit engine sends frames. When the engine signals that its FIFO ran dry in the middle of a frame, the block applies one of two policies. A single configuration bit selects the policy. With the bit clear, the transmitter is switched off and stays off until software starts it again. With the bit set, the block walks the ring from the head of the broken frame. It hands every descriptor of that frame back to the host with an error mark, and it skips any later entries that do not open a frame. It then restarts transmission by itself at the next descriptor that starts a frame and is owned by the controller.

The descriptor port is read combinationally. The block drives a ring index and receives that entry's ownership, start-of-frame and end-of-frame bits in the same cycle. A write-back strobe tells the ring storage to clear the ownership bit and set the error bit of the indexed entry. A launch strobe carries the ring index at which the engine must begin a frame. The engine reports a normal frame end together with the index of that frame's last descriptor. When the scan meets an entry that the host still owns and cannot pass, it holds on that entry and looks again on each poll tick.

Top module: `tx_ufl_recover`

## Requirements
- R1: After reset, `tx_on_o`, `cfg_q_o` and `ufl_err_o` are 0, and no launch or write-back strobe occurs.
- R2: `cfg_q_o` takes `cfg_wd_i` in the cycle after `cfg_we_i`, in any state. A pulse on `rst_reg_rd_i` clears it, and a pulse on `stop_i` leaves it unchanged.
- R3: `start_i` sets `tx_on_o`. The block then seeks forward from the current ring index, leaves entries with start-of-frame 0 untouched, and pulses `xmit_go_o` with `xmit_idx_o` equal to the first entry that has start-of-frame 1 and ownership 1.
- R4: With `cfg_q_o` = 0, an underflow while transmitting drops `tx_on_o` on the next cycle. No launch and no write-back follow.
- R5: With `cfg_q_o` = 1, an underflow makes the block write back (ownership to 0, error to 1) every descriptor of the aborted frame, from its head up to and including the first entry with end-of-frame 1.
- R6: After the aborted frame's end, entries with start-of-frame 0 are skipped unchanged whatever their ownership. The block launches at the next owned start-of-frame entry, and `tx_on_o` stays 1.
- R7: If the scan meets an entry it cannot pass because the host owns it, the ring index and all strobes hold until a `poll_tick_i` pulse. After the pulse the entry is read again.
- R8: An underflow while transmitting sets `ufl_err_o` under either policy. The bit stays set until an `err_clr_i` pulse.
- R9: `frame_done_i` with `done_idx_i` = k makes the seek start at index k+1, wrapping from RING_LEN-1 to 0.
- R10: `stop_i` drops `tx_on_o` on the next cycle and cancels any scan, so no launch follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Write strobe for the recovery-policy bit |
| cfg_wd_i | input | 1 | Write value for the recovery-policy bit |
| cfg_q_o | output | 1 | Current recovery-policy bit (1 = recover, 0 = halt) |
| rst_reg_rd_i | input | 1 | Read of the reset register; clears the policy bit and stops |
| stop_i | input | 1 | Stop command |
| start_i | input | 1 | Start command |
| desc_idx_o | output | IW | Ring index being read or written back |
| desc_own_i | input | 1 | Ownership bit of the indexed entry (1 = controller) |
| desc_stp_i | input | 1 | Start-of-frame bit of the indexed entry |
| desc_enp_i | input | 1 | End-of-frame bit of the indexed entry |
| desc_wb_o | output | 1 | Write back: clear ownership and set error at `desc_idx_o` |
| poll_tick_i | input | 1 | Re-poll strobe |
| xmit_go_o | output | 1 | Launch a frame |
| xmit_idx_o | output | IW | Ring index of the launched frame |
| frame_done_i | input | 1 | Engine finished a frame normally |
| done_idx_i | input | IW | Index of the finished frame's last descriptor |
| ufl_i | input | 1 | FIFO underflow strobe from the engine |
| ufl_err_o | output | 1 | Sticky underflow error |
| err_clr_i | input | 1 | Clears the sticky underflow error |
| tx_on_o | output | 1 | Transmitter on |

## Verification
Recovery is swept over every head position in an eight-entry ring, aborted-frame lengths of one to three, and gaps of zero to two entries before the next frame start. This separates wrap-around errors and end-of-frame handling, and it shows whether gap entries are skipped untouched even when they are controller-owned. The halt policy is tried at every head position, to show that nothing is written back or launched. A host-owned entry inside the aborted frame checks that the block waits for the poll tick. Stop and reset-register reads are placed in the middle of a transmission to show their effect on the policy bit and on the transmitter.

// File: rtl/uflr_pkg.sv
package uflr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_POLL,
    ST_SEND
  } uflr_st_e;
endpackage

// File: rtl/uflr_cfg.sv
module uflr_cfg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic wd_i,
  input  logic clr_i,
  input  logic ufl_evt_i,
  input  logic err_clr_i,
  output logic cfg_o,
  output logic err_o
);
  logic cfg_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= 1'b0;
    else if (clr_i) cfg_q <= 1'b0;
    else if (we_i) cfg_q <= wd_i;
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else if (ufl_evt_i) err_q <= 1'b1;
    else if (err_clr_i) err_q <= 1'b0;
  end

  assign cfg_o = cfg_q;
  assign err_o = err_q;

  // R2
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !clr_i) |=> $stable(cfg_q));
  // R8
  err_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ufl_evt_i |=> err_q);
endmodule

// File: rtl/uflr_ptr.sv
module uflr_ptr #(
  parameter int RING_LEN = 8,
  parameter int IW = (RING_LEN > 1) ? $clog2(RING_LEN) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [IW-1:0] ld_val_i,
  input  logic          adv_i,
  output logic [IW-1:0] idx_o
);
  localparam logic [IW-1:0] LAST = IW'(RING_LEN - 1);
  logic [IW-1:0] idx_q, inc;

  generate
    if ((1 << IW) == RING_LEN) begin : g_pow2
      assign inc = idx_q + 1'b1;
    end else begin : g_cmp
      assign inc = (idx_q == LAST) ? '0 : idx_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else if (ld_i) idx_q <= ld_val_i;
    else if (adv_i) idx_q <= inc;
  end

  assign idx_o = idx_q;

  // R3
  ptr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST);
endmodule

// File: rtl/uflr_ctrl.sv
module uflr_ctrl
  import uflr_pkg::*;
#(
  parameter int RING_LEN = 8,
  parameter int IW = (RING_LEN > 1) ? $clog2(RING_LEN) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          ufl_i,
  input  logic          frame_done_i,
  input  logic [IW-1:0] done_idx_i,
  input  logic          poll_tick_i,
  input  logic          own_i,
  input  logic          stp_i,
  input  logic          enp_i,
  input  logic [IW-1:0] idx_i,
  output logic          ld_o,
  output logic [IW-1:0] ld_val_o,
  output logic          adv_o,
  output logic          wb_o,
  output logic          go_o,
  output logic          ufl_evt_o,
  output logic          tx_on_o
);
  localparam logic [IW-1:0] LAST = IW'(RING_LEN - 1);

  uflr_st_e st_q, st_d;
  logic head_q, head_d;   // entry under scan is head of aborted frame
  logic past_q, past_d;   // aborted frame's end already passed
  logic tx_on_q, tx_on_d;
  logic [IW-1:0] cur_q, cur_d;

  function automatic logic [IW-1:0] wrap_inc(input logic [IW-1:0] v);
    return (v == LAST) ? '0 : v + 1'b1;
  endfunction

  always_comb begin
    st_d     = st_q;
    head_d   = head_q;
    past_d   = past_q;
    tx_on_d  = tx_on_q;
    cur_d    = cur_q;
    ld_o     = 1'b0;
    ld_val_o = idx_i;
    adv_o    = 1'b0;
    wb_o     = 1'b0;
    go_o     = 1'b0;
    if (stop_i) begin
      st_d    = ST_IDLE;
      tx_on_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          tx_on_d = 1'b1;
          st_d    = ST_SCAN;
          head_d  = 1'b0;
          past_d  = 1'b1;
        end
        ST_SCAN: begin
          if (stp_i && !head_q) begin
            if (own_i) begin
              go_o  = 1'b1;
              cur_d = idx_i;
              st_d  = ST_SEND;
            end else st_d = ST_POLL;
          end else if (!past_q) begin
            if (own_i) begin
              wb_o   = 1'b1;
              adv_o  = 1'b1;
              head_d = 1'b0;
              if (enp_i) past_d = 1'b1;
            end else st_d = ST_POLL;
          end else begin
            adv_o  = 1'b1;
            head_d = 1'b0;
          end
        end
        ST_POLL: if (poll_tick_i) st_d = ST_SCAN;
        ST_SEND: begin
          if (ufl_i) begin
            if (cfg_i) begin
              st_d     = ST_SCAN;
              ld_o     = 1'b1;
              ld_val_o = cur_q;
              head_d   = 1'b1;
              past_d   = 1'b0;
            end else begin
              st_d    = ST_IDLE;
              tx_on_d = 1'b0;
            end
          end else if (frame_done_i) begin
            st_d     = ST_SCAN;
            ld_o     = 1'b1;
            ld_val_o = wrap_inc(done_idx_i);
            head_d   = 1'b0;
            past_d   = 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      head_q  <= 1'b0;
      past_q  <= 1'b1;
      tx_on_q <= 1'b0;
      cur_q   <= '0;
    end else begin
      st_q    <= st_d;
      head_q  <= head_d;
      past_q  <= past_d;
      tx_on_q <= tx_on_d;
      cur_q   <= cur_d;
    end
  end

  assign ufl_evt_o = ufl_i && (st_q == ST_SEND);
  assign tx_on_o   = tx_on_q;

  // R3
  go_owned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> (own_i && stp_i && tx_on_q));
  // R5
  wb_owned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_o |-> (own_i && !go_o && !past_q));
  // R4
  halt_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SEND && ufl_i && !cfg_i) |=> (!tx_on_q && st_q == ST_IDLE));
  // R7
  poll_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_POLL && !poll_tick_i && !stop_i) |=> (st_q == ST_POLL && $stable(idx_i)));
  // R10
  stop_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !tx_on_q);
  // R6
  scan_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SCAN || st_q == ST_SEND) |-> tx_on_q);
endmodule

// File: rtl/tx_ufl_recover.sv
module tx_ufl_recover #(
  parameter int RING_LEN = 8,
  parameter int IW = (RING_LEN > 1) ? $clog2(RING_LEN) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic          cfg_wd_i,
  output logic          cfg_q_o,
  input  logic          rst_reg_rd_i,
  input  logic          stop_i,
  input  logic          start_i,
  output logic [IW-1:0] desc_idx_o,
  input  logic          desc_own_i,
  input  logic          desc_stp_i,
  input  logic          desc_enp_i,
  output logic          desc_wb_o,
  input  logic          poll_tick_i,
  output logic          xmit_go_o,
  output logic [IW-1:0] xmit_idx_o,
  input  logic          frame_done_i,
  input  logic [IW-1:0] done_idx_i,
  input  logic          ufl_i,
  output logic          ufl_err_o,
  input  logic          err_clr_i,
  output logic          tx_on_o
);
  logic          cfg, ufl_evt, ld, adv, halt;
  logic [IW-1:0] ld_val, idx;

  assign halt = stop_i || rst_reg_rd_i;

  uflr_cfg u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .wd_i      (cfg_wd_i),
    .clr_i     (rst_reg_rd_i),
    .ufl_evt_i (ufl_evt),
    .err_clr_i (err_clr_i),
    .cfg_o     (cfg),
    .err_o     (ufl_err_o)
  );

  uflr_ptr #(.RING_LEN(RING_LEN), .IW(IW)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (ld),
    .ld_val_i (ld_val),
    .adv_i    (adv),
    .idx_o    (idx)
  );

  uflr_ctrl #(.RING_LEN(RING_LEN), .IW(IW)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_i        (cfg),
    .start_i      (start_i),
    .stop_i       (halt),
    .ufl_i        (ufl_i),
    .frame_done_i (frame_done_i),
    .done_idx_i   (done_idx_i),
    .poll_tick_i  (poll_tick_i),
    .own_i        (desc_own_i),
    .stp_i        (desc_stp_i),
    .enp_i        (desc_enp_i),
    .idx_i        (idx),
    .ld_o         (ld),
    .ld_val_o     (ld_val),
    .adv_o        (adv),
    .wb_o         (desc_wb_o),
    .go_o         (xmit_go_o),
    .ufl_evt_o    (ufl_evt),
    .tx_on_o      (tx_on_o)
  );

  assign cfg_q_o    = cfg;
  assign desc_idx_o = idx;
  assign xmit_idx_o = idx;
endmodule

// File: tb/tb_tx_ufl_recover.sv
module tb_tx_ufl_recover;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_wd = 0, rst_rd = 0, stop = 0, start = 0;
  logic poll = 0, fdone = 0, ufl = 0, eclr = 0;
  logic [IW-1:0] done_idx = '0;
  logic [IW-1:0] didx, xidx;
  logic cfg_q, wb, go, uerr, tx_on;
  logic [N-1:0] own = '0, stp = '0, enp = '0, err = '0;

  int n_chk = 0, n_fail = 0;
  int go_cnt = 0;
  int last_go = 0;
  logic wb_p = 1'b0;
  logic [IW-1:0] wb_i = '0;

  always #2 clk = ~clk;

  tx_ufl_recover #(.RING_LEN(N), .IW(IW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_wd_i(cfg_wd), .cfg_q_o(cfg_q),
    .rst_reg_rd_i(rst_rd), .stop_i(stop), .start_i(start),
    .desc_idx_o(didx), .desc_own_i(own[didx]), .desc_stp_i(stp[didx]),
    .desc_enp_i(enp[didx]), .desc_wb_o(wb), .poll_tick_i(poll),
    .xmit_go_o(go), .xmit_idx_o(xidx), .frame_done_i(fdone),
    .done_idx_i(done_idx), .ufl_i(ufl), .ufl_err_o(uerr),
    .err_clr_i(eclr), .tx_on_o(tx_on)
  );

  always @(posedge clk) begin
    if (go) begin
      go_cnt  <= go_cnt + 1;
      last_go <= int'(xidx);
    end
    wb_p <= wb;
    wb_i <= didx;
  end

  // ring storage applies write-backs away from the sampling edge
  always @(negedge clk) if (wb_p) begin
    own[wb_i] = 1'b0;
    err[wb_i] = 1'b1;
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hw_reset();
    @(negedge clk); rst_n = 1'b0;
    cyc(2); rst_n = 1'b1; cyc(1);
  endtask

  task automatic set_cfg(input logic v);
    @(negedge clk); cfg_we = 1; cfg_wd = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic ring_clear();
    own = '0; stp = '0; enp = '0; err = '0;
  endtask

  task automatic wait_go(input int lim, output bit ok);
    int c0 = go_cnt;
    ok = 0;
    for (int k = 0; k < lim; k++) begin
      @(negedge clk);
      if (go_cnt != c0) begin ok = 1; break; end
    end
  endtask

  task automatic pulse_start(); @(negedge clk); start = 1; @(negedge clk); start = 0; endtask
  task automatic pulse_ufl();   @(negedge clk); ufl = 1;   @(negedge clk); ufl = 0;   endtask
  task automatic pulse_stop();  @(negedge clk); stop = 1;  @(negedge clk); stop = 0;  endtask
  task automatic pulse_poll();  @(negedge clk); poll = 1;  @(negedge clk); poll = 0;  endtask
  task automatic pulse_done(input int k);
    @(negedge clk); fdone = 1; done_idx = IW'(k);
    @(negedge clk); fdone = 0;
  endtask

  // launch a one-entry frame at 0, then reposition via frame_done so the seek starts at h
  task automatic launch_at(input int h, input int len, input int gap, input bit gap_own);
    bit ok;
    ring_clear(); own[0] = 1; stp[0] = 1; enp[0] = 1;
    pulse_start();
    wait_go(20, ok);
    chk(ok && last_go == 0, "R3 initial launch", last_go, 0);
    ring_clear();
    for (int k = 0; k < len; k++) begin
      own[(h + k) % N] = 1;
      stp[(h + k) % N] = (k == 0);
      enp[(h + k) % N] = (k == len - 1);
    end
    for (int k = 0; k < gap; k++) own[(h + len + k) % N] = gap_own;
    own[(h + len + gap) % N] = 1;
    stp[(h + len + gap) % N] = 1;
    enp[(h + len + gap) % N] = 1;
    pulse_done((h + N - 1) % N);
    wait_go(20, ok);
    chk(ok && last_go == h, "R9 seek after frame end", last_go, h);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
  end

  initial begin
    bit ok;
    int c0, n;
    hw_reset();
    // R1
    chk(tx_on == 0, "R1 tx_on", tx_on, 0);
    chk(cfg_q == 0, "R1 cfg", cfg_q, 0);
    chk(uerr == 0, "R1 err", uerr, 0);
    cyc(3);
    chk(go_cnt == 0 && wb == 0, "R1 no strobes", go_cnt, 0);

    // R2
    set_cfg(1); chk(cfg_q == 1, "R2 write 1", cfg_q, 1);
    pulse_stop(); chk(cfg_q == 1, "R2 stop keeps cfg", cfg_q, 1);
    @(negedge clk); rst_rd = 1; @(negedge clk); rst_rd = 0;
    chk(cfg_q == 0, "R2 reset-register read clears", cfg_q, 0);
    set_cfg(1); set_cfg(0); chk(cfg_q == 0, "R2 write 0", cfg_q, 0);

    // R3: non-start entries skipped untouched
    hw_reset();
    ring_clear(); own[1] = 1; own[2] = 1; enp[2] = 1; own[3] = 1; stp[3] = 1;
    pulse_start();
    chk(tx_on == 1, "R3 tx_on after start", tx_on, 1);
    wait_go(20, ok);
    chk(ok && last_go == 3, "R3 first owned start", last_go, 3);
    chk(own[1] == 1 && err[1] == 0 && own[2] == 1, "R3 skipped untouched", int'(own[1]), 1);

    // R10
    set_cfg(1);
    pulse_stop();
    chk(tx_on == 0, "R10 stop drops tx_on", tx_on, 0);
    chk(cfg_q == 1, "R10 cfg kept", cfg_q, 1);
    c0 = go_cnt; pulse_ufl(); cyc(5);
    chk(go_cnt == c0 && uerr == 0, "R10 no launch after stop", go_cnt - c0, 0);

    // R5 R6 R8 R9: recovery sweep
    for (int len = 1; len <= 3; len++)
      for (int gap = 0; gap <= 2; gap++)
        for (int h = 0; h < N; h++) begin
          hw_reset();
          set_cfg(1);
          launch_at(h, len, gap, gap == 2);
          pulse_ufl();
          n = (h + len + gap) % N;
          wait_go(30, ok);
          chk(ok && last_go == n, "R6 relaunch index", last_go, n);
          for (int k = 0; k < len; k++)
            chk(own[(h + k) % N] == 0 && err[(h + k) % N] == 1, "R5 aborted entry returned",
                int'(err[(h + k) % N]), 1);
          for (int k = 0; k < gap; k++)
            chk(own[(h + len + k) % N] == (gap == 2) && err[(h + len + k) % N] == 0,
                "R6 gap entry untouched", int'(err[(h + len + k) % N]), 0);
          chk(tx_on == 1, "R6 tx stays on", tx_on, 1);
          chk(uerr == 1, "R8 err set on recovery", uerr, 1);
        end

    // R4 R8: halt sweep
    for (int h = 0; h < N; h++) begin
      hw_reset();
      launch_at(h, 2, 0, 0);
      c0 = go_cnt;
      pulse_ufl();
      chk(tx_on == 0, "R4 tx off", tx_on, 0);
      cyc(8);
      chk(go_cnt == c0, "R4 no relaunch", go_cnt - c0, 0);
      chk(err == '0 && own[h] == 1, "R4 no write-back", int'(err), 0);
      chk(uerr == 1, "R8 err set on halt", uerr, 1);
      @(negedge clk); eclr = 1; @(negedge clk); eclr = 0;
      chk(uerr == 0, "R8 err cleared", uerr, 0);
    end

    // R7: host-owned entry inside the aborted frame
    hw_reset();
    set_cfg(1);
    launch_at(3, 2, 0, 0);
    own[4] = 0;
    c0 = go_cnt;
    pulse_ufl();
    cyc(10);
    chk(go_cnt == c0, "R7 holds without tick", go_cnt - c0, 0);
    chk(err[3] == 1 && err[4] == 0 && didx == 4, "R7 waits on entry 4", int'(didx), 4);
    own[4] = 1;
    pulse_poll();
    wait_go(20, ok);
    chk(ok && last_go == 5, "R7 resumes after tick", last_go, 5);
    chk(err[4] == 1, "R7 entry returned after tick", int'(err[4]), 1);

    report();
  end
endmodule